// File: doc/BRIEF.md
# Camera Timing Signal Conditioner

This block sits between a parallel camera port and a base-configuration Camera Link transmitter. It runs on the fast output clock, oversamples the camera pixel clock, and on the selected camera clock edge captures the pixel word together with the line, frame and data qualifiers. Each qualifier is converted to active-high according to its own polarity bit. The block then drives a data-valid that is either held high or forwarded from the camera.

For slow cameras, a rate multiplier setting lets every captured pixel occupy 2, 4 or 8 fast output cycles. Data-valid then marks only the first of those cycles, and a new camera edge is not accepted until the current pixel has been held for its full window. The configuration inputs are static mode bits. The block copies them into its working settings only while both line and frame outputs are inactive, so a mode change never lands in the middle of a line.

Top module: `camTimingCond`

## Requirements
- R1: While rstN is low, outData, outLval, outFval and outDval are all 0 at the next clock edge.
- R2: A pixel is captured when camPclk makes the selected transition (0 to 1 when cfgFallEdge=0, 1 to 0 when cfgFallEdge=1). The outputs change at the second rising clk edge after the first clk edge that samples the new camPclk level, and are unchanged after the first.
- R3: outLval is the captured camLval when cfgLvalLow=0, and its inverse when cfgLvalLow=1.
- R4: outFval is the captured camFval when cfgFvalLow=0, and its inverse when cfgFvalLow=1.
- R5: With cfgLineScan=1, outFval stays 0 whatever camFval does.
- R6: With cfgDvalPass=1 and cfgMult=00, outDval is the captured camDval, inverted when cfgDvalLow=1.
- R7: With cfgDvalPass=0 and cfgMult=00, outDval is 1 in every cycle after reset.
- R8: cfgMult encodes the output factor N: 00 off (N=1), 01 2x, 10 4x, 11 8x. With N>1, outDval is high for exactly the first output cycle after each capture and low in every other cycle. If cfgDvalPass=1, that first cycle carries the normalised camDval instead of 1.
- R9: With N>1, a camera edge that arrives before the current pixel has been held for N output cycles is dropped. The outputs then keep the previous pixel and outDval stays 0.
- R10: Changes on the cfg inputs take effect only after outLval and outFval have both been 0 at a clock edge. A change made while either is 1 waits for the line or frame to end.
- R11: outData, outLval and outFval change only at a capture and hold their value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast output clock |
| rstN | input | 1 | Synchronous reset, active low |
| camPclk | input | 1 | Camera pixel clock, oversampled by clk |
| camData | input | DATA_W | Camera pixel word |
| camLval | input | 1 | Camera line qualifier, raw polarity |
| camFval | input | 1 | Camera frame qualifier, raw polarity |
| camDval | input | 1 | Camera data qualifier, raw polarity |
| cfgLvalLow | input | 1 | Line qualifier is active low |
| cfgFvalLow | input | 1 | Frame qualifier is active low |
| cfgDvalLow | input | 1 | Camera data qualifier is active low |
| cfgDvalPass | input | 1 | Forward camera data qualifier |
| cfgFallEdge | input | 1 | Capture on falling camPclk edge |
| cfgLineScan | input | 1 | Force frame output inactive |
| cfgMult | input | MULT_SEL_W | Output rate factor select |
| outData | output | DATA_W | Captured pixel word |
| outLval | output | 1 | Line valid, active high |
| outFval | output | 1 | Frame valid, active high |
| outDval | output | 1 | Data valid, active high |

## Verification
The bench builds the block with its defaults: a 16-bit pixel word and a two-bit multiplier select, so factors 1, 2, 4 and 8 are all available. With the largest factor only 8 cycles long, a deliberately early camera edge can be placed inside the hold window in a handful of cycles, and the drop rule can be checked directly. Holding the line active across a mode write brings the deferred-configuration path within reach: a later idle cycle shows the new mode taking over.

// File: rtl/camCondPkg.sv
package camCondPkg;

  // Working configuration, copied from the cfg pins while idle
  typedef struct packed {
    logic       lvalLow;
    logic       fvalLow;
    logic       dvalLow;
    logic       dvalPass;
    logic       fallEdge;
    logic       lineScan;
    logic [1:0] mult;
  } camCfg_t;

  // Strobes and settings handed from control to datapath
  typedef struct packed {
    logic capture;
    logic multOn;
    logic dvalPass;
    logic lvalInv;
    logic fvalInv;
    logic dvalInv;
    logic fvalKill;
  } camCtrl_t;

endpackage

// File: rtl/camCondCtrl.sv
module camCondCtrl
  import camCondPkg::*;
#(
  parameter int MULT_SEL_W = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     camPclk,
  input  camCfg_t  cfgIn,
  input  logic     outLval,
  input  logic     outFval,
  output camCtrl_t ctrl
);

  localparam int MAX_FACTOR = 1 << ((1 << MULT_SEL_W) - 1);
  localparam int CNT_W      = (MAX_FACTOR > 2) ? $clog2(MAX_FACTOR) : 1;

  camCfg_t          cfgAct;
  logic             pclkS1;
  logic             pclkS2;
  logic [CNT_W-1:0] holdCnt;
  logic [CNT_W:0]   factor;
  logic             edgeSeen;
  logic             multOn;
  logic             capture;

  // Working copy of the mode bits, refreshed only between lines/frames
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgAct <= '0;
    end else if (!outLval && !outFval) begin
      cfgAct <= cfgIn;
    end
  end

  // Two-register pixel clock tap for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pclkS1 <= 1'b0;
      pclkS2 <= 1'b0;
    end else begin
      pclkS1 <= camPclk;
      pclkS2 <= pclkS1;
    end
  end

  always_comb begin
    if (cfgAct.fallEdge) edgeSeen = pclkS2 & ~pclkS1;
    else                 edgeSeen = pclkS1 & ~pclkS2;
  end

  assign multOn  = (cfgAct.mult != '0);
  assign factor  = (CNT_W + 1)'(1) << cfgAct.mult;
  assign capture = edgeSeen && (!multOn || holdCnt == '0);

  // Remaining cycles before the current pixel may be replaced
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (capture && multOn) begin
      holdCnt <= CNT_W'(factor - 1'b1);
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  always_comb begin
    ctrl          = '0;
    ctrl.capture  = capture;
    ctrl.multOn   = multOn;
    ctrl.dvalPass = cfgAct.dvalPass;
    ctrl.lvalInv  = cfgAct.lvalLow;
    ctrl.fvalInv  = cfgAct.fvalLow;
    ctrl.dvalInv  = cfgAct.dvalLow;
    ctrl.fvalKill = cfgAct.lineScan;
  end

  // R9
  hold_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (capture && multOn) |=> (!capture || !multOn));

  // R10
  cfg_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outLval || outFval) |=> $stable(cfgAct));

endmodule

// File: rtl/camCondData.sv
module camCondData
  import camCondPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  camCtrl_t          ctrl,
  input  logic [DATA_W-1:0] camData,
  input  logic              camLval,
  input  logic              camFval,
  input  logic              camDval,
  output logic [DATA_W-1:0] outData,
  output logic              outLval,
  output logic              outFval,
  output logic              outDval
);

  logic [DATA_W-1:0] dataS1;
  logic              lvalS1;
  logic              fvalS1;
  logic              dvalS1;
  logic              lvalNorm;
  logic              fvalNorm;
  logic              dvalNorm;
  logic              dvalNext;

  // First pipeline stage, aligned with the pixel clock tap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataS1 <= '0;
      lvalS1 <= 1'b0;
      fvalS1 <= 1'b0;
      dvalS1 <= 1'b0;
    end else begin
      dataS1 <= camData;
      lvalS1 <= camLval;
      fvalS1 <= camFval;
      dvalS1 <= camDval;
    end
  end

  assign lvalNorm = lvalS1 ^ ctrl.lvalInv;
  assign fvalNorm = (fvalS1 ^ ctrl.fvalInv) & ~ctrl.fvalKill;
  assign dvalNorm = dvalS1 ^ ctrl.dvalInv;

  // Second stage: output hold registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData <= '0;
      outLval <= 1'b0;
      outFval <= 1'b0;
    end else if (ctrl.capture) begin
      outData <= dataS1;
      outLval <= lvalNorm;
      outFval <= fvalNorm;
    end
  end

  always_comb begin
    if (ctrl.multOn) begin
      dvalNext = ctrl.capture & (ctrl.dvalPass ? dvalNorm : 1'b1);
    end else if (ctrl.dvalPass) begin
      dvalNext = ctrl.capture ? dvalNorm : outDval;
    end else begin
      dvalNext = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) outDval <= 1'b0;
    else       outDval <= dvalNext;
  end

  // R11
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.capture |=> ($stable(outData) && $stable(outLval) && $stable(outFval)));

  // R8
  dval_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.multOn && outDval) |=> (!outDval || !ctrl.multOn));

  // R7
  dval_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.multOn && !ctrl.dvalPass) |=> outDval);

  // R5
  line_scan_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.fvalKill |=> !outFval);

endmodule

// File: rtl/camTimingCond.sv
module camTimingCond
  import camCondPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int MULT_SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  camPclk,
  input  logic [DATA_W-1:0]     camData,
  input  logic                  camLval,
  input  logic                  camFval,
  input  logic                  camDval,
  input  logic                  cfgLvalLow,
  input  logic                  cfgFvalLow,
  input  logic                  cfgDvalLow,
  input  logic                  cfgDvalPass,
  input  logic                  cfgFallEdge,
  input  logic                  cfgLineScan,
  input  logic [MULT_SEL_W-1:0] cfgMult,
  output logic [DATA_W-1:0]     outData,
  output logic                  outLval,
  output logic                  outFval,
  output logic                  outDval
);

  camCfg_t  cfgIn;
  camCtrl_t ctrl;

  always_comb begin
    cfgIn          = '0;
    cfgIn.lvalLow  = cfgLvalLow;
    cfgIn.fvalLow  = cfgFvalLow;
    cfgIn.dvalLow  = cfgDvalLow;
    cfgIn.dvalPass = cfgDvalPass;
    cfgIn.fallEdge = cfgFallEdge;
    cfgIn.lineScan = cfgLineScan;
    cfgIn.mult     = 2'(cfgMult);
  end

  camCondCtrl #(.MULT_SEL_W(MULT_SEL_W)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .camPclk (camPclk),
    .cfgIn   (cfgIn),
    .outLval (outLval),
    .outFval (outFval),
    .ctrl    (ctrl)
  );

  camCondData #(.DATA_W(DATA_W)) i_data (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .camData (camData),
    .camLval (camLval),
    .camFval (camFval),
    .camDval (camDval),
    .outData (outData),
    .outLval (outLval),
    .outFval (outFval),
    .outDval (outDval)
  );

endmodule

// File: tb/test_camTimingCond.sv
`timescale 1ns/1ps
module test_camTimingCond;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        camPclk = 1'b0;
  logic [15:0] camData = '0;
  logic        camLval = 1'b0;
  logic        camFval = 1'b0;
  logic        camDval = 1'b0;
  logic        cfgLvalLow = 1'b0;
  logic        cfgFvalLow = 1'b0;
  logic        cfgDvalLow = 1'b0;
  logic        cfgDvalPass = 1'b0;
  logic        cfgFallEdge = 1'b0;
  logic        cfgLineScan = 1'b0;
  logic [1:0]  cfgMult = 2'b00;
  logic [15:0] outData;
  logic        outLval;
  logic        outFval;
  logic        outDval;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  camTimingCond i_camTimingCond (
    .clk(clk), .rstN(rstN), .camPclk(camPclk), .camData(camData),
    .camLval(camLval), .camFval(camFval), .camDval(camDval),
    .cfgLvalLow(cfgLvalLow), .cfgFvalLow(cfgFvalLow), .cfgDvalLow(cfgDvalLow),
    .cfgDvalPass(cfgDvalPass), .cfgFallEdge(cfgFallEdge), .cfgLineScan(cfgLineScan),
    .cfgMult(cfgMult), .outData(outData), .outLval(outLval), .outFval(outFval),
    .outDval(outDval)
  );

  task automatic chk(input string tg, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tg, act, exp);
    end
  endtask

  // One camera pixel: inactive half, active edge, then checks
  task automatic pixel(input logic [15:0] d, input logic l, input logic f, input logic dv,
                       input int h, input logic [15:0] eD, input logic eL, input logic eF,
                       input logic eDv1, input logic eDv2, input string tg);
    logic [15:0] snap;
    logic act;
    act = ~cfgFallEdge;
    @(negedge clk);
    camData = d; camLval = l; camFval = f; camDval = dv;
    camPclk = ~act;
    repeat (h) @(negedge clk);
    snap = outData;
    camPclk = act;
    @(negedge clk);
    chk({tg, " R2 latency"}, 32'(outData), 32'(snap));
    @(negedge clk);
    chk({tg, " data"}, 32'(outData), 32'(eD));
    chk({tg, " lval"}, 32'(outLval), 32'(eL));
    chk({tg, " fval"}, 32'(outFval), 32'(eF));
    chk({tg, " dval first"}, 32'(outDval), 32'(eDv1));
    @(negedge clk);
    chk({tg, " dval second"}, 32'(outDval), 32'(eDv2));
    chk({tg, " R11 hold"}, 32'(outData), 32'(eD));
    repeat ((h > 3) ? h - 3 : 0) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset;
    idle(3);
    chk("R1 data", 32'(outData), 0);
    chk("R1 lval", 32'(outLval), 0);
    chk("R1 fval", 32'(outFval), 0);
    chk("R1 dval", 32'(outDval), 0);
    rstN = 1'b1;
    idle(3);
    chk("R7 dval after reset", 32'(outDval), 1);
  endtask

  task automatic testRiseFall;
    pixel(16'h1234, 1, 1, 0, 2, 16'h1234, 1, 1, 1, 1, "R2 rise a");
    pixel(16'h00ab, 0, 0, 0, 2, 16'h00ab, 0, 0, 1, 1, "R2 rise b");
    cfgFallEdge = 1'b1; idle(3);
    pixel(16'hbeef, 1, 0, 0, 2, 16'hbeef, 1, 0, 1, 1, "R2 fall a");
    pixel(16'h0f0f, 0, 0, 0, 1, 16'h0f0f, 0, 0, 1, 1, "R2 fall b");
    cfgFallEdge = 1'b0; idle(3);
  endtask

  task automatic testPolarity;
    cfgLvalLow = 1'b1; idle(3);
    pixel(16'h0101, 0, 0, 0, 2, 16'h0101, 1, 0, 1, 1, "R3 low active");
    pixel(16'h0202, 1, 0, 0, 2, 16'h0202, 0, 0, 1, 1, "R3 low idle");
    cfgLvalLow = 1'b0; cfgFvalLow = 1'b1; idle(3);
    pixel(16'h0303, 1, 0, 0, 2, 16'h0303, 1, 1, 1, 1, "R4 low active");
    pixel(16'h0404, 0, 1, 0, 2, 16'h0404, 0, 0, 1, 1, "R4 low idle");
    cfgFvalLow = 1'b0; cfgLineScan = 1'b1; idle(3);
    pixel(16'h0505, 1, 1, 0, 2, 16'h0505, 1, 0, 1, 1, "R5 fval forced");
    pixel(16'h0606, 0, 1, 0, 2, 16'h0606, 0, 0, 1, 1, "R5 end line");
    cfgLineScan = 1'b0; idle(3);
  endtask

  task automatic testPass;
    cfgDvalPass = 1'b1; idle(3);
    pixel(16'h1111, 0, 0, 1, 2, 16'h1111, 0, 0, 1, 1, "R6 high dv1");
    pixel(16'h2222, 0, 0, 0, 2, 16'h2222, 0, 0, 0, 0, "R6 high dv0");
    cfgDvalLow = 1'b1; idle(3);
    pixel(16'h3333, 0, 0, 0, 2, 16'h3333, 0, 0, 1, 1, "R6 low dv0");
    pixel(16'h4444, 0, 0, 1, 2, 16'h4444, 0, 0, 0, 0, "R6 low dv1");
    cfgDvalPass = 1'b0; cfgDvalLow = 1'b0; idle(3);
    chk("R7 held high", 32'(outDval), 1);
  endtask

  task automatic testMult;
    cfgMult = 2'b01; idle(3);
    chk("R8 idle low", 32'(outDval), 0);
    pixel(16'h5151, 1, 1, 0, 2, 16'h5151, 1, 1, 1, 0, "R8 2x a");
    pixel(16'h5252, 0, 0, 0, 2, 16'h5252, 0, 0, 1, 0, "R8 2x b");
    cfgMult = 2'b10; cfgDvalPass = 1'b1; idle(3);
    pixel(16'h5353, 0, 0, 0, 2, 16'h5353, 0, 0, 0, 0, "R8 4x pass dv0");
    pixel(16'h5454, 0, 0, 1, 2, 16'h5454, 0, 0, 1, 0, "R8 4x pass dv1");
    cfgMult = 2'b11; cfgDvalPass = 1'b0; idle(12);
    pixel(16'h6161, 1, 0, 0, 4, 16'h6161, 1, 0, 1, 0, "R8 8x a");
    pixel(16'h6262, 0, 0, 0, 1, 16'h6161, 1, 0, 0, 0, "R9 8x early dropped");
    idle(12);
    pixel(16'h6363, 0, 0, 0, 2, 16'h6363, 0, 0, 1, 0, "R9 8x accepted");
    cfgMult = 2'b00; idle(10);
  endtask

  task automatic testCfgGate;
    pixel(16'h7171, 1, 0, 0, 2, 16'h7171, 1, 0, 1, 1, "R10 line start");
    cfgMult = 2'b11; idle(3);
    chk("R10 deferred dval", 32'(outDval), 1);
    pixel(16'h7272, 1, 0, 0, 1, 16'h7272, 1, 0, 1, 1, "R10 mid line");
    pixel(16'h7373, 0, 0, 0, 1, 16'h7373, 0, 0, 1, 1, "R10 line end");
    @(negedge clk);
    chk("R10 new mode active", 32'(outDval), 0);
    cfgMult = 2'b00; idle(12);
    chk("R10 mode restored", 32'(outDval), 1);
  endtask

  initial begin
    testReset();
    testRiseFall();
    testPolarity();
    testPass();
    testMult();
    testCfgGate();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule